// File: doc/BRIEF.md
# Direct-Page Address Former

This block turns the short 8-bit operand of a direct-addressing-mode access into a full address. A page register supplies the upper byte of a 16-bit local address, and the operand supplies the lower byte. When the access comes from a global instruction, a second 7-bit page register is placed above that 16-bit result to form a 23-bit global address.

Both page registers sit on a small synchronous register bus with a write port and a read port. Reads return data one cycle after the request. The direct page register locks after its first write while the system runs in a normal mode. In special modes it stays writable without limit. The upper-page register can be written at any time.

The address outputs are combinational. They follow the register contents that hold in the current cycle, so a page write affects address formation only from the next cycle onward.

Top module: `dpage_addr_unit`

## Requirements
- R1: After reset the direct page, the global page and the read data output are all zero, and the write lock is clear.
- R2: A read at register address 0x11 returns the direct page value on `reg_rdata[7:0]` one cycle after the read request.
- R3: In normal mode (`special_mode`=0) only the first direct page write after reset takes effect. Every later normal-mode write to it is ignored until the next reset. Writes made in special mode do not set the lock.
- R4: In special mode (`special_mode`=1) the direct page accepts any number of writes, even after the lock has been set.
- R5: `loc_addr[15:8]` equals the direct page and `loc_addr[7:0]` equals `acc_operand`.
- R6: `glb_addr[22:16]` equals the global page and `glb_addr[15:0]` equals `loc_addr`. `glb_valid` is 1 only when `acc_valid`=1 and `acc_global`=1. Example: direct page 0x80, global page 0x14 and operand 0x00 give 0x148000.
- R7: The global page sits at register address 0x10 and can be written in any mode. Bit 7 is dropped on write and reads as 0.
- R8: When a register is read and written in the same cycle, the read returns the old value. The new value is returned by reads from the next cycle onward.
- R9: Reads of any other register address return 0, and writes to any other address change neither page register.
- R10: An access made in the same cycle as a direct page write is formed from the old page value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| special_mode | input | 1 | 1 = special mode, where the direct page stays writable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| acc_valid | input | 1 | A direct-addressing access is presented |
| acc_global | input | 1 | 1 = the access comes from a global instruction |
| acc_operand | input | 8 | 8-bit direct operand |
| loc_addr | output | 16 | Formed local address |
| glb_addr | output | 23 | Formed global address |
| glb_valid | output | 1 | Global address is valid |

## Verification
Two pairs of functions can coincide in one cycle: a page-register write with a read of the same register, and a page-register write with an address-forming access. The bench provokes each pair by driving both on the same half cycle. It judges the first pair through the scoreboard, which expects the old value from that read and the new value from the read after it. It judges the second pair by checking that the address formed in the write cycle still carries the old page and that the address formed one cycle later carries the new page.

// File: rtl/dpage_pkg.sv
package dpage_pkg;
   localparam int unsigned DP_ADDR_DEF = 8'h11;
   localparam int unsigned GP_ADDR_DEF = 8'h10;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DP   = 2'd1,
      SEL_GP   = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/dpage_regfile.sv
module dpage_regfile
   import dpage_pkg::*;
#(
   parameter int unsigned REG_AW  = 8,
   parameter int unsigned REG_DW  = 8,
   parameter int unsigned PAGE_W  = 8,
   parameter int unsigned GPAGE_W = 7,
   parameter int unsigned DP_ADDR = DP_ADDR_DEF,
   parameter int unsigned GP_ADDR = GP_ADDR_DEF,
   parameter bit          RD_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [REG_DW-1:0] wdata,
   output logic [REG_DW-1:0] rdata,
   output logic [PAGE_W-1:0] dp_q,
   output logic [GPAGE_W-1:0] gp_q
);
   localparam logic [REG_AW-1:0] DP_A = REG_AW'(DP_ADDR);
   localparam logic [REG_AW-1:0] GP_A = REG_AW'(GP_ADDR);

   generate
      if (REG_DW < PAGE_W || REG_DW < GPAGE_W) begin : g_bad_dw
         $error("register data width narrower than a page register");
      end
      if (DP_ADDR == GP_ADDR) begin : g_bad_map
         $error("page registers share one address");
      end
   endgenerate

   reg_sel_e          sel;
   logic              lock_q;
   logic              dp_we;
   logic              gp_we;
   logic [REG_DW-1:0] rd_next;

   always_comb begin
      if (addr == DP_A)      sel = SEL_DP;
      else if (addr == GP_A) sel = SEL_GP;
      else                   sel = SEL_NONE;
   end

   assign dp_we = wr_en && (sel == SEL_DP) && (special_mode || !lock_q);
   assign gp_we = wr_en && (sel == SEL_GP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dp_q   <= '0;
         gp_q   <= '0;
         lock_q <= 1'b0;
      end else begin
         if (dp_we) dp_q <= wdata[PAGE_W-1:0];
         if (gp_we) gp_q <= wdata[GPAGE_W-1:0];
         if (wr_en && (sel == SEL_DP) && !special_mode) lock_q <= 1'b1;
      end
   end

   always_comb begin
      rd_next = '0;
      case (sel)
         SEL_DP:  rd_next[PAGE_W-1:0]  = dp_q;
         SEL_GP:  rd_next[GPAGE_W-1:0] = gp_q;
         default: rd_next = '0;
      endcase
   end

   generate
      if (RD_HOLD) begin : g_rd_hold
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= rd_next;
         end
      end else begin : g_rd_clear
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_en ? rd_next : '0;
         end
      end
   endgenerate

   // R3
   dp_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == DP_A && !special_mode && lock_q) |=> $stable(dp_q));

   // R3
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R4
   dp_special_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == DP_A && special_mode) |=> (dp_q == $past(wdata[PAGE_W-1:0])));

   // R2
   dp_rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == DP_A) |=> (rdata[PAGE_W-1:0] == $past(dp_q)));

   // R9
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr != DP_A && addr != GP_A) |=> (rdata == '0));

   generate
      if (REG_DW > GPAGE_W) begin : g_gp_top
         // R7
         gp_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == GP_A) |=> (rdata[REG_DW-1:GPAGE_W] == '0));
      end
   endgenerate
endmodule

// File: rtl/dpage_addr_form.sv
module dpage_addr_form #(
   parameter int unsigned PAGE_W  = 8,
   parameter int unsigned OPER_W  = 8,
   parameter int unsigned GPAGE_W = 7,
   localparam int unsigned LOC_W  = PAGE_W + OPER_W,
   localparam int unsigned GLB_W  = GPAGE_W + LOC_W
) (
   input  logic [PAGE_W-1:0]  dp,
   input  logic [GPAGE_W-1:0] gp,
   input  logic [OPER_W-1:0]  operand,
   input  logic               acc_valid,
   input  logic               acc_global,
   output logic [LOC_W-1:0]   loc_addr,
   output logic [GLB_W-1:0]   glb_addr,
   output logic               glb_valid
);
   assign loc_addr  = {dp, operand};
   assign glb_addr  = {gp, dp, operand};
   assign glb_valid = acc_valid && acc_global;
endmodule

// File: rtl/dpage_addr_unit.sv
module dpage_addr_unit
   import dpage_pkg::*;
#(
   parameter int unsigned REG_AW  = 8,
   parameter int unsigned REG_DW  = 8,
   parameter int unsigned PAGE_W  = 8,
   parameter int unsigned OPER_W  = 8,
   parameter int unsigned GPAGE_W = 7,
   parameter int unsigned DP_ADDR = DP_ADDR_DEF,
   parameter int unsigned GP_ADDR = GP_ADDR_DEF,
   parameter bit          RD_HOLD = 1'b1,
   localparam int unsigned LOC_W  = PAGE_W + OPER_W,
   localparam int unsigned GLB_W  = GPAGE_W + LOC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              acc_valid,
   input  logic              acc_global,
   input  logic [OPER_W-1:0] acc_operand,
   output logic [LOC_W-1:0]  loc_addr,
   output logic [GLB_W-1:0]  glb_addr,
   output logic              glb_valid
);
   generate
      if (REG_AW < 5 || (DP_ADDR >> REG_AW) != 0 || (GP_ADDR >> REG_AW) != 0) begin : g_bad_aw
         $error("register address does not fit the address width");
      end
   endgenerate

   logic [PAGE_W-1:0]  dp_q;
   logic [GPAGE_W-1:0] gp_q;

   dpage_regfile #(
      .REG_AW (REG_AW),
      .REG_DW (REG_DW),
      .PAGE_W (PAGE_W),
      .GPAGE_W(GPAGE_W),
      .DP_ADDR(DP_ADDR),
      .GP_ADDR(GP_ADDR),
      .RD_HOLD(RD_HOLD)
   ) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .special_mode(special_mode),
      .wr_en       (reg_wr_en),
      .rd_en       (reg_rd_en),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .rdata       (reg_rdata),
      .dp_q        (dp_q),
      .gp_q        (gp_q)
   );

   dpage_addr_form #(
      .PAGE_W (PAGE_W),
      .OPER_W (OPER_W),
      .GPAGE_W(GPAGE_W)
   ) form_i (
      .dp        (dp_q),
      .gp        (gp_q),
      .operand   (acc_operand),
      .acc_valid (acc_valid),
      .acc_global(acc_global),
      .loc_addr  (loc_addr),
      .glb_addr  (glb_addr),
      .glb_valid (glb_valid)
   );

   // R6
   glb_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      glb_valid |-> (acc_valid && acc_global && glb_addr[LOC_W-1:0] == loc_addr));

   // R5
   loc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_addr[OPER_W-1:0] == acc_operand);

   // R10
   loc_old_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == REG_AW'(DP_ADDR)) |-> (loc_addr[LOC_W-1:OPER_W] == dp_q));
endmodule

// File: tb/dpage_addr_unit_tb_top.sv
module dpage_addr_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_DP = 8'h11;
   localparam logic [7:0] A_GP = 8'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        special_mode = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic        reg_rd_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        acc_valid = 1'b0;
   logic        acc_global = 1'b0;
   logic [7:0]  acc_operand = '0;
   logic [15:0] loc_addr;
   logic [22:0] glb_addr;
   logic        glb_valid;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } rd_item_t;
   rd_item_t sb_q[$];
   logic     rd_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpage_addr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acc_valid(acc_valid), .acc_global(acc_global), .acc_operand(acc_operand),
      .loc_addr(loc_addr), .glb_addr(glb_addr), .glb_valid(glb_valid)
   );

   // monitor: a read issued before a rising edge is judged at the next falling edge
   always @(posedge clk) rd_seen <= reg_rd_en && rst_n;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_q.size() == 0) begin
            fails++; checks++;
            $display("FAIL scoreboard: read data %h with no expected item", reg_rdata);
         end else begin
            rd_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (reg_rdata !== it.exp) begin
               fails++;
               $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.exp);
            end
         end
      end
   end

   // driver: one bus cycle, pushing the expected read data when reading
   task automatic bus(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [7:0] wd, input logic [7:0] exp, input string tag);
      @(negedge clk);
      reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = wd;
      if (rd) sb_q.push_back('{exp: exp, tag: tag});
      @(negedge clk);
      reg_wr_en = 1'b0; reg_rd_en = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic v, input logic g, input logic [7:0] op);
      @(negedge clk);
      acc_valid = v; acc_global = g; acc_operand = op;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      do_reset();
      #1;
      chk("R1 rdata after reset", 32'(reg_rdata), 32'h0);
      bus(0, 1, A_DP, 8'h00, 8'h00, "R1 dp reset");
      bus(0, 1, A_GP, 8'h00, 8'h00, "R1 gp reset");
      access(1, 0, 8'h00);
      chk("R1 loc after reset", 32'(loc_addr), 32'h0000);

      // normal mode lock
      bus(1, 0, A_DP, 8'h80, 8'h00, "");
      bus(0, 1, A_DP, 8'h00, 8'h80, "R2 R3 first write");
      bus(1, 0, A_DP, 8'h22, 8'h00, "");
      bus(0, 1, A_DP, 8'h00, 8'h80, "R3 second write ignored");
      access(1, 0, 8'h5A);
      chk("R5 loc", 32'(loc_addr), 32'h805A);

      // global page
      bus(1, 0, A_GP, 8'h94, 8'h00, "");
      bus(0, 1, A_GP, 8'h00, 8'h14, "R7 bit7 dropped");
      bus(1, 0, A_GP, 8'h14, 8'h00, "");
      bus(0, 1, A_GP, 8'h00, 8'h14, "R7 rewrite");
      access(1, 1, 8'h00);
      chk("R6 glb example", 32'(glb_addr), 32'h148000);
      chk("R6 glb_valid global", 32'(glb_valid), 32'h1);
      access(1, 0, 8'h00);
      chk("R6 glb_valid local", 32'(glb_valid), 32'h0);
      access(0, 1, 8'h00);
      chk("R6 glb_valid idle", 32'(glb_valid), 32'h0);

      // unmapped
      bus(0, 1, 8'h12, 8'h00, 8'h00, "R9 unmapped read");
      bus(1, 0, 8'h12, 8'hFF, 8'h00, "");
      bus(0, 1, A_DP, 8'h00, 8'h80, "R9 dp untouched");
      bus(0, 1, A_GP, 8'h00, 8'h14, "R9 gp untouched");

      // special mode
      special_mode = 1'b1;
      bus(1, 0, A_DP, 8'h3C, 8'h00, "");
      bus(0, 1, A_DP, 8'h00, 8'h3C, "R4 special write 1");
      bus(1, 0, A_DP, 8'hC3, 8'h00, "");
      bus(0, 1, A_DP, 8'h00, 8'hC3, "R4 special write 2");

      // same-cycle read and write
      bus(1, 1, A_DP, 8'h55, 8'hC3, "R8 old value same cycle");
      bus(0, 1, A_DP, 8'h00, 8'h55, "R8 new value next cycle");

      // same-cycle write and access
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = A_DP; reg_wdata = 8'h66;
      acc_valid = 1'b1; acc_global = 1'b1; acc_operand = 8'h01;
      #1;
      chk("R10 loc old page", 32'(loc_addr), 32'h5501);
      chk("R10 glb old page", 32'(glb_addr), 32'h145501);
      @(negedge clk);
      reg_wr_en = 1'b0;
      #1;
      chk("R10 loc new page", 32'(loc_addr), 32'h6601);

      // back to normal, lock still set
      special_mode = 1'b0;
      bus(1, 0, A_DP, 8'h77, 8'h00, "");
      bus(0, 1, A_DP, 8'h00, 8'h66, "R3 lock survives special");

      // reset, special write does not lock
      do_reset();
      bus(0, 1, A_DP, 8'h00, 8'h00, "R1 dp cleared by reset");
      special_mode = 1'b1;
      bus(1, 0, A_DP, 8'h11, 8'h00, "");
      special_mode = 1'b0;
      bus(1, 0, A_DP, 8'h22, 8'h00, "");
      bus(0, 1, A_DP, 8'h00, 8'h22, "R3 special write leaves lock clear");
      bus(1, 0, A_DP, 8'h33, 8'h00, "");
      bus(0, 1, A_DP, 8'h00, 8'h22, "R3 locked after normal write");

      repeat (3) @(negedge clk);
      chk("scoreboard drained", 32'(sb_q.size()), 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule